// File: doc/BRIEF.md
# Load-Use Interlock and Stall Controller

This block sits beside the decode stage of a five-stage in-order processor pipeline. Load results leave the data memory only when the load reaches write-back, so an instruction in decode that reads the destination of a load still in the ALU or memory stage cannot be served by the bypass network. The block compares the decode-stage source register numbers against the destinations of the instructions in those two stages. When a load in flight matches, it freezes the program counter and the decode-stage instruction register and makes the ALU-stage instruction register take a NOP instead of the decoded instruction.

A dependent instruction right behind a load waits two cycles. A dependent instruction one slot further back waits one cycle. Producers that are not loads are covered by bypassing and never stall. Branches are resolved early and their single delay slot always executes, so this block has no flush path. All inputs and outputs are plain control pins with no handshake. The outputs are combinational from the inputs, so they act in the same cycle as the decode-stage comparison.

Top module: `load_use_interlock`

## Requirements
- R1: While `rst_n` is low, `fetch_en` is 1 and `nop_ins` is 1, whatever the other inputs are. The surrounding pipeline therefore loads a NOP into the ALU-stage register and the block asserts no stall.
- R2: If a used, non-zero decode source equals `ex_dst` while `ex_is_load` and `ex_wen` are both 1, then in that same cycle `fetch_en` is 0 and `nop_ins` is 1. An instruction directly behind such a load is stalled for exactly two cycles.
- R3: If a used, non-zero decode source equals `mem_dst` while `mem_is_load` and `mem_wen` are both 1, the block stalls. An instruction with one unrelated instruction between it and the load is stalled for exactly one cycle.
- R4: An instruction with two or more instructions between it and the load it reads is never stalled.
- R5: A source register number of 0 never causes a stall.
- R6: A source whose use flag (bit k of `dec_src_use` for field k) is 0 never causes a stall, even when its register number matches a load destination.
- R7: A producer in the ALU or memory stage whose load flag is 0 never causes a stall.
- R8: A stage whose write enable is 0 never causes a stall, even if its load flag is set. This is the case of an inserted NOP. After `nop_ins` is 1, the next ALU-stage write enable is 0.
- R9: A match on any one source field is enough to stall. Outside reset, `fetch_en` and `nop_ins` are always complementary.
- R10: When no stall condition holds and `rst_n` is high, `fetch_en` is 1 and `nop_ins` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used only for the temporal checks |
| rst_n | input | 1 | Active-low reset |
| dec_src_idx | input | NUM_SRC*REG_W | Decode source register numbers; field k at bits [k*REG_W +: REG_W] |
| dec_src_use | input | NUM_SRC | Bit k set when source field k is actually read |
| ex_dst | input | REG_W | Destination register of the ALU-stage instruction |
| ex_is_load | input | 1 | ALU-stage instruction is a load |
| ex_wen | input | 1 | ALU-stage instruction writes the register file |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_wen | input | 1 | Memory-stage instruction writes the register file |
| fetch_en | output | 1 | Clock enable for the PC and decode-stage instruction register (1 = advance) |
| nop_ins | output | 1 | 1 = ALU-stage instruction register loads a NOP |

## Verification
The temporal checks assume that the surrounding pipeline obeys the block. The ALU-stage contents move into the memory stage on every clock. A NOP with write enable cleared enters the ALU stage whenever `nop_ins` is high. The decode instruction stays in place while `fetch_en` is low. Under those conditions a stall lasts at most two cycles, and a stall caused only by the memory stage lasts one. The bench drives the three stage slots from its own pipeline model. That model advances by the stall it expects, not by the one the design outputs, so the stimulus always matches a well-behaved pipeline.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  // Producer slot order inside the hazard detector
  typedef enum int {
    PROD_ALU = 0,
    PROD_MEM = 1
  } prod_slot_e;

  localparam int NUM_PROD = 2;

  // A producer can only block decode while it is a load that still writes
  function automatic logic load_in_flight(input logic is_load, input logic wen);
    return is_load & wen;
  endfunction

endpackage

// File: rtl/ilk_src_match.sv
module ilk_src_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_idx,
  input  logic             src_use,
  input  logic [REG_W-1:0] prod_dst,
  input  logic             prod_live,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_IDX = '0;

  // Register zero is hard-wired, so it never carries a pending load
  assign hit = src_use & prod_live & (src_idx != ZERO_IDX) & (src_idx == prod_dst);

endmodule

// File: rtl/ilk_hazard_detect.sv
module ilk_hazard_detect #(
  parameter int REG_W    = 5,
  parameter int NUM_SRC  = 2,
  parameter int NUM_PROD = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0]  src_idx,
  input  logic [NUM_SRC-1:0]             src_use,
  input  logic [NUM_PROD-1:0][REG_W-1:0] prod_dst,
  input  logic [NUM_PROD-1:0]            prod_is_load,
  input  logic [NUM_PROD-1:0]            prod_wen,
  output logic [NUM_PROD-1:0]            prod_hit
);
  logic [NUM_PROD-1:0][NUM_SRC-1:0] pair_hit;
  logic [NUM_PROD-1:0]              prod_live;

  for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
    assign prod_live[p] = ilk_pkg::load_in_flight(prod_is_load[p], prod_wen[p]);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      ilk_src_match #(.REG_W(REG_W)) u_match (
        .src_idx  (src_idx[s]),
        .src_use  (src_use[s]),
        .prod_dst (prod_dst[p]),
        .prod_live(prod_live[p]),
        .hit      (pair_hit[p][s])
      );
    end

    assign prod_hit[p] = |pair_hit[p];
  end

endmodule

// File: rtl/ilk_stall_ctl.sv
module ilk_stall_ctl #(
  parameter int NUM_PROD = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PROD-1:0] prod_hit,
  output logic                stall,
  output logic                fetch_en,
  output logic                nop_ins
);
  always_comb begin
    stall    = rst_n & (|prod_hit);
    fetch_en = ~stall;
    // During reset the ALU-stage register is cleared to a NOP
    nop_ins  = stall | ~rst_n;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (fetch_en && nop_ins); // R1
    end
  end

  AST_OUTPUTS_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en != nop_ins); // R9

  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |=> !stall); // R2

endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0][REG_W-1:0] dec_src_idx,
  input  logic [NUM_SRC-1:0]            dec_src_use,
  input  logic [REG_W-1:0]              ex_dst,
  input  logic                         ex_is_load,
  input  logic                         ex_wen,
  input  logic [REG_W-1:0]              mem_dst,
  input  logic                         mem_is_load,
  input  logic                         mem_wen,
  output logic                         fetch_en,
  output logic                         nop_ins
);
  import ilk_pkg::*;

  localparam int ALU_I = int'(PROD_ALU);
  localparam int MEM_I = int'(PROD_MEM);

  logic [NUM_PROD-1:0][REG_W-1:0] prod_dst;
  logic [NUM_PROD-1:0]            prod_is_load;
  logic [NUM_PROD-1:0]            prod_wen;
  logic [NUM_PROD-1:0]            prod_hit;
  logic                           stall;

  always_comb begin
    prod_dst[ALU_I]     = ex_dst;
    prod_is_load[ALU_I] = ex_is_load;
    prod_wen[ALU_I]     = ex_wen;
    prod_dst[MEM_I]     = mem_dst;
    prod_is_load[MEM_I] = mem_is_load;
    prod_wen[MEM_I]     = mem_wen;
  end

  ilk_hazard_detect #(
    .REG_W   (REG_W),
    .NUM_SRC (NUM_SRC),
    .NUM_PROD(NUM_PROD)
  ) u_detect (
    .src_idx     (dec_src_idx),
    .src_use     (dec_src_use),
    .prod_dst    (prod_dst),
    .prod_is_load(prod_is_load),
    .prod_wen    (prod_wen),
    .prod_hit    (prod_hit)
  );

  ilk_stall_ctl #(.NUM_PROD(NUM_PROD)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .prod_hit(prod_hit),
    .stall   (stall),
    .fetch_en(fetch_en),
    .nop_ins (nop_ins)
  );

  AST_BUBBLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    nop_ins |=> !ex_wen); // R8

  AST_MEM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !prod_hit[ALU_I]) |=> !stall); // R3

  AST_NO_LOAD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ex_is_load && ex_wen) && !(mem_is_load && mem_wen)) |-> (fetch_en && !nop_ins)); // R7

endmodule

// File: tb/tb_load_use_interlock.sv
`timescale 1ns/1ps
module tb_load_use_interlock;
  localparam int REG_W   = 5;
  localparam int NUM_SRC = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                          rst_n;
  logic [NUM_SRC-1:0][REG_W-1:0] dec_src_idx;
  logic [NUM_SRC-1:0]            dec_src_use;
  logic [REG_W-1:0]              ex_dst, mem_dst;
  logic                          ex_is_load, ex_wen, mem_is_load, mem_wen;
  logic                          fetch_en, nop_ins;

  load_use_interlock #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) dut (
    .clk(clk), .rst_n(rst_n),
    .dec_src_idx(dec_src_idx), .dec_src_use(dec_src_use),
    .ex_dst(ex_dst), .ex_is_load(ex_is_load), .ex_wen(ex_wen),
    .mem_dst(mem_dst), .mem_is_load(mem_is_load), .mem_wen(mem_wen),
    .fetch_en(fetch_en), .nop_ins(nop_ins)
  );

  typedef struct {
    int s0; int s1; bit u0; bit u1; int d; bit w; bit ld;
  } ins_t;

  int   n_chk = 0;
  int   n_bad = 0;
  ins_t dec, ex, mem;

  function automatic ins_t mk(bit ld, bit w, int d, int s0, bit u0, int s1, bit u1);
    ins_t t;
    t.ld = ld; t.w = w; t.d = d; t.s0 = s0; t.u0 = u0; t.s1 = s1; t.u1 = u1;
    return t;
  endfunction

  function automatic ins_t nop();
    return mk(0, 0, 0, 0, 0, 0, 0);
  endfunction

  // Does consumer c read a pending load result of producer p?
  function automatic bit dep(ins_t c, ins_t p);
    if (!(p.ld && p.w) || p.d == 0) return 1'b0;
    if (c.u0 && c.s0 == p.d) return 1'b1;
    if (c.u1 && c.s1 == p.d) return 1'b1;
    return 1'b0;
  endfunction

  task automatic drive();
    dec_src_idx[0] = REG_W'(dec.s0);
    dec_src_idx[1] = REG_W'(dec.s1);
    dec_src_use    = {dec.u1, dec.u0};
    ex_dst         = REG_W'(ex.d);
    ex_is_load     = ex.ld;
    ex_wen         = ex.w;
    mem_dst        = REG_W'(mem.d);
    mem_is_load    = mem.ld;
    mem_wen        = mem.w;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Runs a program through the bench pipeline model; compares every cycle
  task automatic run(input ins_t prog[$], input int exp_st, input string tag);
    int idx;
    int st;
    dec = (prog.size() > 0) ? prog[0] : nop();
    idx = 1;
    ex  = nop();
    mem = nop();
    st  = 0;
    for (int c = 0; c < prog.size() + 6; c++) begin
      bit    ea, em, e;
      string ctag;
      drive();
      #1;
      ea = dep(dec, ex);
      em = dep(dec, mem);
      e  = ea || em;
      if (ea)      ctag = "R2";
      else if (em) ctag = "R3";
      else         ctag = "R10";
      check({fetch_en, nop_ins} == (e ? 2'b01 : 2'b10), ctag,
            int'({fetch_en, nop_ins}), e ? 1 : 2);
      if (!fetch_en) st++;
      @(negedge clk);
      mem = ex;
      if (e) ex = nop();
      else begin
        ex  = dec;
        dec = (idx < prog.size()) ? prog[idx] : nop();
        idx++;
      end
    end
    if (exp_st >= 0) check(st == exp_st, tag, st, exp_st);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    ins_t p[$];
    rst_n = 1'b0;
    dec = nop(); ex = nop(); mem = nop();
    drive();
    repeat (3) @(negedge clk);
    // R1: reset forces no stall and a NOP even with a live hazard on the inputs
    dec = mk(0, 1, 6, 5, 1, 2, 1);
    ex  = mk(1, 1, 5, 1, 1, 0, 0);
    mem = mk(1, 1, 2, 1, 1, 0, 0);
    drive();
    #1;
    check(fetch_en === 1'b1 && nop_ins === 1'b1, "R1",
          int'({fetch_en, nop_ins}), 3);
    dec = nop(); ex = nop(); mem = nop();
    drive();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(fetch_en === 1'b1 && nop_ins === 1'b0, "R10",
          int'({fetch_en, nop_ins}), 2);
    @(negedge clk);

    // R2: use directly after load -> two stall cycles
    p = '{mk(1,1,5,1,1,0,0), mk(0,1,6,5,1,2,1)};
    run(p, 2, "R2");
    // R3: one instruction between -> one stall cycle
    p = '{mk(1,1,5,1,1,0,0), mk(0,1,7,1,1,2,1), mk(0,1,6,5,1,2,1)};
    run(p, 1, "R3");
    // R4: two instructions between -> no stall
    p = '{mk(1,1,5,1,1,0,0), mk(0,1,7,1,1,2,1), mk(0,1,8,1,1,2,1), mk(0,1,6,5,1,5,1)};
    run(p, 0, "R4");
    // R5: register zero
    p = '{mk(1,1,0,1,1,0,0), mk(0,1,6,0,1,0,1)};
    run(p, 0, "R5");
    // R6: unused source field matching
    p = '{mk(1,1,5,1,1,0,0), mk(0,1,6,1,1,5,0)};
    run(p, 0, "R6");
    p = '{mk(1,1,5,1,1,0,0), mk(0,1,6,5,0,3,1)};
    run(p, 0, "R6");
    // R7: non-load producer is bypassed
    p = '{mk(0,1,5,1,1,2,1), mk(0,1,6,5,1,5,1)};
    run(p, 0, "R7");
    // R8: load flag with write enable cleared
    p = '{mk(1,0,5,1,1,0,0), mk(0,1,6,5,1,2,1)};
    run(p, 0, "R8");
    // R9: match on second source only
    p = '{mk(1,1,5,1,1,0,0), mk(0,1,6,2,1,5,1)};
    run(p, 2, "R9");
    // R9: two loads, consumer reads both
    p = '{mk(1,1,5,1,1,0,0), mk(1,1,6,2,1,0,0), mk(0,1,7,5,1,6,1)};
    run(p, 2, "R9");
    // R2: load-to-load address dependence then use
    p = '{mk(1,1,5,1,1,0,0), mk(1,1,6,5,1,0,0), mk(0,1,7,6,1,6,1)};
    run(p, 4, "R2");

    // R10: random programs over a small register set
    for (int r = 0; r < 25; r++) begin
      p.delete();
      for (int i = 0; i < 30; i++) begin
        p.push_back(mk(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
                       int'($urandom_range(0, 3)),
                       int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                       int'($urandom_range(0, 3)), 1'($urandom_range(0, 1))));
      end
      run(p, -1, "R10");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule